// File: doc/BRIEF.md
# Memory read-modify-write logic unit

This block carries out a bitwise AND, OR or XOR between a register operand and a value held in memory, then writes the result back to the same memory location. A command gives an 8-bit opcode, the memory address (the content of a second register) and the register operand. The opcode selects both the operation and the access size: a full 32-bit word, a halfword or a byte. The block reads the addressed word over a simple request/ready memory bus. It merges the sized result into that word and writes it back with byte-lane enables, so only the operand's bytes change.

Commands enter on a valid/ready channel. `cmd_ready` is high only while the unit is idle. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. While an operation is in progress the source must hold its command, because `cmd_ready` stays low. On the memory side each request is held, with all its fields stable, until `mem_ready` is seen.

The negative and zero flags are registered outputs. They are computed from the sized result only. They change on the edge where the write completes, and `done` pulses in that same cycle. Byte lanes are little-endian: byte k of a word occupies bits 8k+7..8k, a halfword sits in lanes {1,0} when address bit 1 is 0 and in lanes {3,2} when it is 1, and a byte sits in the lane given by address bits 1..0. Alignment is the caller's responsibility.

Top module: `rmw_logic_unit`

## Requirements
- R1: Opcodes 0x84, 0x85 and 0x86 perform AND at word, halfword and byte size. Opcodes 0x94, 0x95 and 0x96 perform OR at those sizes. Opcodes 0x9C, 0x9D and 0x9E perform XOR at those sizes.
- R2: A halfword operation uses the low 16 bits of `cmd_data`, and a byte operation uses the low 8 bits. The memory operand is taken from the lane picked by the low address bits, with the little-endian lane order given above.
- R3: The write drives `mem_be` with a bit set for exactly the lanes of the operand. Those are all four lanes for a word, two adjacent lanes for a halfword and one lane for a byte. Every byte outside the operand keeps its old value in memory.
- R4: Each accepted command makes exactly one read (`mem_we`=0, `mem_be` all ones) and then exactly one write (`mem_we`=1), both to `cmd_addr`.
- R5: While `mem_req` is high and `mem_ready` is low, the request is still present on the next cycle, with `mem_addr`, `mem_we`, `mem_wdata` and `mem_be` unchanged.
- R6: The write request is not raised until the read has completed, that is, until the edge where `mem_req` and `mem_ready` are both high with `mem_we`=0.
- R7: After the write, `flag_n` equals the top bit of the sized result (bit 31, 15 or 7) and `flag_z` is 1 exactly when the sized result is zero. Neither flag changes on any edge except the one where `done` is high.
- R8: `done` is high for exactly the cycle in which the write handshake (`mem_req`, `mem_we` and `mem_ready` all high) occurs, and at no other time.
- R9: `cmd_ready` is high only while no operation is in progress, and `mem_req` is low whenever `cmd_ready` is high.
- R10: An opcode outside the nine listed in R1 is accepted and discarded. It causes no memory request, no `done` pulse and no flag change.
- R11: After reset `cmd_ready` is 1, `mem_req` and `done` are 0, and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command valid |
| cmd_ready | output | 1 | Unit idle, command accepted on this edge if valid |
| cmd_op | input | 8 | Opcode selecting operation and size |
| cmd_addr | input | ADDR_W | Memory address of the operand |
| cmd_data | input | DATA_W | Register operand |
| mem_req | output | 1 | Memory request, held until ready |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | ADDR_W | Memory address |
| mem_be | output | DATA_W/8 | Byte-lane enables for the write |
| mem_wdata | output | DATA_W | Write data, merged word |
| mem_ready | input | 1 | Memory completes the current request |
| mem_rdata | input | DATA_W | Read data, valid with mem_ready on a read |
| done | output | 1 | Pulse in the cycle the write completes |
| flag_n | output | 1 | Negative flag from the sized result |
| flag_z | output | 1 | Zero flag from the sized result |

## Verification
The bench sweeps all nine opcodes over every legal lane offset, with operand patterns chosen so that the sized result is sometimes zero while other bytes of the word are not, and sometimes has its sized sign bit set while bit 31 is clear. A design that took N or Z from the full word, picked the wrong lane or used the wrong lane order would produce wrong flags, or would corrupt a byte that should have kept its value. Memory wait states of zero to two cycles catch a unit that drops its request early or starts the write before the read data arrives. Every one of the other 247 opcodes is also issued, to catch decoding that touches memory or the flags when it should not.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

  typedef enum logic [1:0] {
    LOP_AND = 2'd0,
    LOP_OR  = 2'd1,
    LOP_XOR = 2'd2
  } lop_e;

  typedef enum logic [1:0] {
    SZ_WORD = 2'd0,
    SZ_HALF = 2'd1,
    SZ_BYTE = 2'd2
  } sz_e;

  typedef struct packed {
    logic legal;
    lop_e op;
    sz_e  sz;
  } cmd_dec_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } st_e;

endpackage

// File: rtl/rmw_decode.sv
module rmw_decode
  import rmw_pkg::*;
(
  input  logic [7:0] opcode,
  output cmd_dec_t   dec
);

  logic [3:0] hi;
  logic [3:0] lo;
  logic       lo_low_set;
  logic       lo_high_set;

  assign hi          = opcode[7:4];
  assign lo          = opcode[3:0];
  assign lo_low_set  = (lo == 4'h4) || (lo == 4'h5) || (lo == 4'h6);
  assign lo_high_set = (lo == 4'hC) || (lo == 4'hD) || (lo == 4'hE);

  always_comb begin
    dec.legal = 1'b0;
    dec.op    = LOP_AND;
    if (hi == 4'h8 && lo_low_set) begin
      dec.legal = 1'b1;
      dec.op    = LOP_AND;
    end else if (hi == 4'h9 && lo_low_set) begin
      dec.legal = 1'b1;
      dec.op    = LOP_OR;
    end else if (hi == 4'h9 && lo_high_set) begin
      dec.legal = 1'b1;
      dec.op    = LOP_XOR;
    end
    case (lo[1:0])
      2'd0:    dec.sz = SZ_WORD;
      2'd1:    dec.sz = SZ_HALF;
      default: dec.sz = SZ_BYTE;
    endcase
  end

endmodule

// File: rtl/rmw_lane_alu.sv
module rmw_lane_alu
  import rmw_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  lop_e              op,
  input  sz_e               sz,
  input  logic [OFF_W-1:0]  byte_off,
  input  logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] wdata,
  output logic [LANES-1:0]  be,
  output logic              res_n,
  output logic              res_z
);

  logic [OFF_W-1:0]  lane_base;
  logic [OFF_W:0]    nbytes;
  logic [OFF_W+2:0]  shamt;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] mem_val;
  logic [DATA_W-1:0] reg_val;
  logic [DATA_W-1:0] res;

  always_comb begin
    mask = '0;
    case (sz)
      SZ_HALF: begin
        lane_base    = {byte_off[OFF_W-1:1], 1'b0};
        nbytes       = (OFF_W+1)'(2);
        mask[15:0]   = '1;
      end
      SZ_BYTE: begin
        lane_base    = byte_off;
        nbytes       = (OFF_W+1)'(1);
        mask[7:0]    = '1;
      end
      default: begin
        lane_base    = '0;
        nbytes       = (OFF_W+1)'(LANES);
        mask         = '1;
      end
    endcase
  end

  assign shamt   = {lane_base, 3'b000};
  assign mem_val = (rdata >> shamt) & mask;
  assign reg_val = operand & mask;

  always_comb begin
    case (op)
      LOP_OR:  res = mem_val | reg_val;
      LOP_XOR: res = mem_val ^ reg_val;
      default: res = mem_val & reg_val;
    endcase
  end

  assign wdata = (rdata & ~(mask << shamt)) | (res << shamt);

  for (genvar k = 0; k < LANES; k++) begin : g_lane_en
    assign be[k] = ((OFF_W+1)'(k) >= {1'b0, lane_base}) &&
                   ((OFF_W+1)'(k) <  ({1'b0, lane_base} + nbytes));
  end

  always_comb begin
    case (sz)
      SZ_HALF: res_n = res[15];
      SZ_BYTE: res_n = res[7];
      default: res_n = res[DATA_W-1];
    endcase
  end

  assign res_z = (res == '0);

endmodule

// File: rtl/rmw_seq.sv
module rmw_seq
  import rmw_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  cmd_dec_t          dec,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  output lop_e              cur_op,
  output sz_e               cur_sz,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [DATA_W-1:0] cur_data,
  input  logic [DATA_W-1:0] alu_wdata,
  input  logic [LANES-1:0]  alu_be,
  input  logic              alu_n,
  input  logic              alu_z,
  output logic              mem_req,
  output logic              mem_we,
  output logic [LANES-1:0]  mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  output logic              done,
  output logic              flag_n,
  output logic              flag_z
);

  st_e               state;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  be_q;
  logic              n_q;
  logic              z_q;
  logic              rd_fire;
  logic              wr_fire;

  assign cmd_ready = (state == ST_IDLE);
  assign mem_req   = (state == ST_READ) || (state == ST_WRITE);
  assign mem_we    = (state == ST_WRITE);
  assign mem_be    = (state == ST_WRITE) ? be_q : '1;
  assign mem_wdata = wdata_q;
  assign rd_fire   = (state == ST_READ) && mem_ready;
  assign wr_fire   = (state == ST_WRITE) && mem_ready;
  assign done      = wr_fire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cur_op   <= LOP_AND;
      cur_sz   <= SZ_WORD;
      cur_addr <= '0;
      cur_data <= '0;
      wdata_q  <= '0;
      be_q     <= '0;
      n_q      <= 1'b0;
      z_q      <= 1'b0;
      flag_n   <= 1'b0;
      flag_z   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (cmd_valid && dec.legal) begin
            state    <= ST_READ;
            cur_op   <= dec.op;
            cur_sz   <= dec.sz;
            cur_addr <= cmd_addr;
            cur_data <= cmd_data;
          end
        end
        ST_READ: begin
          if (rd_fire) begin
            state   <= ST_WRITE;
            wdata_q <= alu_wdata;
            be_q    <= alu_be;
            n_q     <= alu_n;
            z_q     <= alu_z;
          end
        end
        ST_WRITE: begin
          if (wr_fire) begin
            state  <= ST_IDLE;
            flag_n <= n_q;
            flag_z <= z_q;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rmw_logic_unit.sv
module rmw_logic_unit
  import rmw_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [7:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]  mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done,
  output logic              flag_n,
  output logic              flag_z
);

  cmd_dec_t          dec;
  lop_e              cur_op;
  sz_e               cur_sz;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_data;
  logic [DATA_W-1:0] alu_wdata;
  logic [LANES-1:0]  alu_be;
  logic              alu_n;
  logic              alu_z;

  rmw_decode u_decode (
    .opcode (cmd_op),
    .dec    (dec)
  );

  rmw_lane_alu #(.DATA_W(DATA_W)) u_alu (
    .op       (cur_op),
    .sz       (cur_sz),
    .byte_off (cur_addr[OFF_W-1:0]),
    .rdata    (mem_rdata),
    .operand  (cur_data),
    .wdata    (alu_wdata),
    .be       (alu_be),
    .res_n    (alu_n),
    .res_z    (alu_z)
  );

  rmw_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .dec       (dec),
    .cmd_addr  (cmd_addr),
    .cmd_data  (cmd_data),
    .cur_op    (cur_op),
    .cur_sz    (cur_sz),
    .cur_addr  (cur_addr),
    .cur_data  (cur_data),
    .alu_wdata (alu_wdata),
    .alu_be    (alu_be),
    .alu_n     (alu_n),
    .alu_z     (alu_z),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_be    (mem_be),
    .mem_wdata (mem_wdata),
    .mem_ready (mem_ready),
    .done      (done),
    .flag_n    (flag_n),
    .flag_z    (flag_z)
  );

  assign mem_addr = cur_addr;

endmodule

// File: rtl/rmw_logic_unit_chk.sv
module rmw_logic_unit_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  localparam int LANES = DATA_W / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [LANES-1:0]  mem_be,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ready,
  input logic              done,
  input logic              flag_n,
  input logic              flag_z
);

  logic [ADDR_W-1:0] rd_addr_q;
  logic              rd_seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_addr_q <= '0;
      rd_seen_q <= 1'b0;
    end else if (mem_req && mem_ready && !mem_we) begin
      rd_addr_q <= mem_addr;
      rd_seen_q <= 1'b1;
    end else if (mem_req && mem_ready && mem_we) begin
      rd_seen_q <= 1'b0;
    end
  end

  assert_be_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 ||
                             $countones(mem_be) == LANES));

  assert_same_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_addr == rd_addr_q));

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) &&
                                 $stable(mem_be) && $stable(mem_wdata)));

  assert_write_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> rd_seen_q);

  assert_flags_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> ($stable(flag_n) && $stable(flag_z)));

  assert_done_at_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (mem_req && mem_we && mem_ready));

  assert_write_gives_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ready) |-> done);

  assert_idle_no_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !mem_req);

endmodule

bind rmw_logic_unit rmw_logic_unit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/rmw_logic_unit_tb_top.sv
`timescale 1ns/1ps
module rmw_logic_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [7:0]  cmd_op = 8'h00;
  logic [31:0] cmd_addr = '0;
  logic [31:0] cmd_data = '0;
  logic        mem_req;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        done;
  logic        flag_n;
  logic        flag_z;

  always #5 clk = ~clk;

  rmw_logic_unit dut_i (.*);

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [31:0] mem [16];
  int wait_cycles = 0;
  int wcnt = 0;
  int n_reads = 0;
  int n_writes = 0;
  int done_err = 0;
  logic [31:0] rd_addr = '0;
  logic [31:0] wr_addr = '0;
  bit done_seen = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Memory model: decides ready at the falling edge; handshake completes at the next rising edge.
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ready = 1'b0;
      wcnt = 0;
    end else if (mem_req && wcnt == wait_cycles) begin
      mem_ready = 1'b1;
      wcnt = 0;
      if (!mem_we) begin
        mem_rdata = mem[mem_addr[5:2]];
        rd_addr = mem_addr;
        n_reads++;
      end else begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[5:2]][8*b +: 8] = mem_wdata[8*b +: 8];
        wr_addr = mem_addr;
        n_writes++;
      end
      #1;
      if (done !== mem_we) done_err++;
      if (mem_we) done_seen = 1;
    end else begin
      mem_ready = 1'b0;
      if (mem_req) wcnt++;
      #1;
      if (done !== 1'b0) done_err++;
    end
  end

  function automatic bit is_legal(input logic [7:0] op);
    return (op[7:4] == 4'h8 && op[3:0] >= 4'h4 && op[3:0] <= 4'h6) ||
           (op[7:4] == 4'h9 && op[3:0] >= 4'h4 && op[3:0] <= 4'h6) ||
           (op[7:4] == 4'h9 && op[3:0] >= 4'hC && op[3:0] <= 4'hE);
  endfunction

  // Expected result from R1, R2, R7.
  task automatic model(input logic [7:0] op, input logic [31:0] addr, input logic [31:0] old,
                       input logic [31:0] opnd, output logic [31:0] neww, output logic n,
                       output logic z);
    int nb;
    int base;
    logic [31:0] mask;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] r;
    nb   = (op[1:0] == 2'd0) ? 4 : (op[1:0] == 2'd1) ? 2 : 1;
    base = (nb == 4) ? 0 : (nb == 2) ? (addr[1] ? 2 : 0) : int'(addr[1:0]);
    mask = (nb == 4) ? 32'hFFFF_FFFF : (nb == 2) ? 32'h0000_FFFF : 32'h0000_00FF;
    a = (old >> (8 * base)) & mask;
    b = opnd & mask;
    if (op[7:4] == 4'h8) r = a & b;
    else if (op[3:0] < 4'h8) r = a | b;
    else r = a ^ b;
    neww = (old & ~(mask << (8 * base))) | (r << (8 * base));
    n = r[8 * nb - 1];
    z = (r == 32'h0);
  endtask

  task automatic run_op(input logic [7:0] op, input logic [31:0] addr, input logic [31:0] old,
                        input logic [31:0] opnd, input int wt);
    logic [31:0] exp_w;
    logic        exp_n;
    logic        exp_z;
    logic        prev_n;
    logic        prev_z;
    int          guard;
    mem[addr[5:2]] = old;
    wait_cycles = wt;
    n_reads = 0;
    n_writes = 0;
    done_seen = 0;
    prev_n = flag_n;
    prev_z = flag_z;
    model(op, addr, old, opnd, exp_w, exp_n, exp_z);
    cmd_valid = 1'b1;
    cmd_op = op;
    cmd_addr = addr;
    cmd_data = opnd;
    @(negedge clk);
    cmd_valid = 1'b0;
    guard = 0;
    while (!done_seen && guard < 50) begin
      #3;
      if (!done_seen) begin
        @(negedge clk);
        guard++;
      end
    end
    // done observed; handshake edge not yet reached
    check(done_seen && flag_n == prev_n && flag_z == prev_z && cmd_ready == 1'b0,
          "R7/R9 flags held and busy before write edge", {30'd0, flag_n, flag_z},
          {30'd0, prev_n, prev_z});
    @(negedge clk);
    #2;
    check(mem[addr[5:2]] == exp_w, "R1/R2/R3 memory word", mem[addr[5:2]], exp_w);
    check(flag_n == exp_n && flag_z == exp_z, "R7 flags", {30'd0, flag_n, flag_z},
          {30'd0, exp_n, exp_z});
    check(n_reads == 1 && n_writes == 1 && rd_addr == addr && wr_addr == addr,
          "R4 one read then one write at address", wr_addr, addr);
  endtask

  initial begin
    logic [31:0] mem_pats [4];
    logic [31:0] opd_pats [4];
    mem_pats = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h8040_2010, 32'h5A3C_96E1};
    opd_pats = '{32'hFFFF_FFFF, 32'h0000_0000, 32'h8080_8080, 32'hA5C3_0F7E};
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(cmd_ready == 1'b1 && mem_req == 1'b0 && done == 1'b0 && flag_n == 1'b0 &&
          flag_z == 1'b0, "R11 reset state",
          {27'd0, cmd_ready, mem_req, done, flag_n, flag_z}, 32'h10);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_ready == 1'b1 && mem_req == 1'b0, "R11 idle after reset",
          {30'd0, cmd_ready, mem_req}, 32'h2);

    // R1 R2 R3 R4 R5 R6 R7 R8 sweep
    for (int g = 0; g < 3; g++)
      for (int s = 0; s < 3; s++)
        for (int off = 0; off < 4; off++)
          for (int p = 0; p < 4; p++)
            for (int q = 0; q < 4; q++) begin
              logic [7:0]  op;
              logic [31:0] addr;
              int          al;
              op = ((g == 0) ? 8'h84 : (g == 1) ? 8'h94 : 8'h9C) + 8'(s);
              al = (s == 0) ? 0 : (s == 1) ? (off & 2) : off;
              addr = 32'(((p * 4 + q) % 16) * 4 + al) + 32'h0000_1000;
              run_op(op, addr, mem_pats[p], opd_pats[q], (p + q + off) % 3);
            end

    // R10 every other opcode is discarded
    for (int o = 0; o < 256; o++) begin
      if (!is_legal(8'(o))) begin
        logic prev_n;
        logic prev_z;
        bit   bad;
        prev_n = flag_n;
        prev_z = flag_z;
        n_reads = 0;
        n_writes = 0;
        bad = 0;
        cmd_valid = 1'b1;
        cmd_op = 8'(o);
        cmd_addr = 32'h0000_1004;
        cmd_data = 32'hFFFF_FFFF;
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int c = 0; c < 3; c++) begin
          #2;
          if (mem_req || done) bad = 1;
          @(negedge clk);
        end
        check(!bad && n_reads == 0 && n_writes == 0 && flag_n == prev_n &&
              flag_z == prev_z && cmd_ready, "R10 unknown opcode ignored", 32'(o), 32'hFFFF);
      end
    end

    check(done_err == 0, "R8 done only at write handshake", 32'(done_err), 32'd0);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule